// File: doc/BRIEF.md
# Hardwired Multi-Cycle Accumulator Processor

This block is a small processor with one accumulator register whose control is hardwired: a step counter marks the steps t1, t2, t3, t4 of the current machine cycle, and a combinational decoder combines the current cycle kind, the step, the opcode held in the instruction register and a zero flag. From these it picks the register transfers for that step. Every instruction goes through a fetch cycle, an optional indirect cycle, an execute cycle and, when an interrupt is accepted, an interrupt cycle. The registers are the memory address register (MAR), memory buffer register (MBR), program counter (PC), instruction register (IR) and accumulator (R1).

The processor drives a plain word memory. The address port always shows MAR, and the write-data port always shows MBR. Read data is expected on the read port in the step after MAR is loaded. A write is committed at the clock edge that ends a step with write-enable high. An external interrupt request line is honoured only at the end of an execute cycle. Four instructions exist: add-to-accumulator, increment-and-skip-if-zero, branch-and-save-return-address, and halt. Every other opcode acts as a one-step no-op.

Top module: `hw_seq_cpu`

## Requirements
- R1: While reset is held, the following hold: PC = 0, accumulator = 0, cycle code = 0, step = 0 and write-enable low. The interrupt enable is set by reset.
- R2: The fetch cycle has three steps: t1 copies PC into MAR; t2 loads MBR from memory and increments PC; t3 copies MBR into IR. No other cycle is decided before t3.
- R3: An instruction word has the opcode in bits 15..12, the indirect flag in bit 11 and the address in bits 10..0. Opcode 0x1 is add, 0x2 is increment-and-skip, 0x3 is branch-and-save and 0xF is halt. Every other opcode gives an execute cycle of one step that changes no register or memory word.
- R4: Add takes three execute steps (MAR from address field, MBR from memory, R1 = R1 + MBR modulo 2^16).
- R5: Increment-and-skip takes four execute steps: MAR from address field, MBR from memory, MBR + 1, then the new value is written back. In that same last step PC is incremented if the new value is zero.
- R6: Branch-and-save takes three execute steps. It stores the address of the next instruction (zero-extended) at X, then continues at X+1.
- R7: For opcodes 0x1..0x3 with bit 11 set, a three-step indirect cycle runs between fetch and execute. It replaces the address field of IR with bits 10..0 of the word at that address. For other opcodes bit 11 has no effect.
- R8: An interrupt is taken only when the request is high in the last execute step and the interrupt enable is set. Its three steps store PC at word 0 and set PC to 1. Taking an interrupt clears the interrupt enable, and only reset sets it again.
- R9: Halt enters cycle code 4 directly after its fetch. The processor then stays there with PC, accumulator and memory unchanged until reset.
- R10: Writes go to the address in MAR with the data in MBR. Write-enable is never high in two consecutive steps, and the memory contents after each instruction match the instruction-level results.
- R11: The cycle code reads 0 for fetch, 1 for indirect, 2 for execute, 3 for interrupt and 4 for halted. The step output reads 0 for t1, and every new cycle starts at step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one step per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 1 | Interrupt request level |
| mem_rdata | input | 16 | Word read from memory at mem_addr |
| mem_addr | output | 11 | Memory address (MAR) |
| mem_wdata | output | 16 | Memory write data (MBR) |
| mem_we | output | 1 | Memory write enable for this step |
| acc_o | output | 16 | Accumulator R1 |
| pc_o | output | 11 | Program counter |
| cycle_o | output | 3 | Current cycle code |
| step_o | output | 2 | Current step, 0 = t1 |

## Verification
Two functions can fall in the same clock step. The first is the increment-and-skip write-back and its conditional PC increment, both in t4. The second is the last step of an execute cycle, where the interrupt decision is made and the instruction finishes. The bench provokes the first with operands of 0xFFFF, which wrap to zero, placed next to ordinary values. It provokes the second with request pulses that are either held through the execute cycle or dropped during fetch. Each case is judged by the PC, the accumulator and the number of clocks at the next instruction boundary, and by comparing the whole memory with an instruction-level model.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  localparam int OP_W   = 4;
  localparam int STEP_W = 2;

  localparam logic [OP_W-1:0] OP_ADD  = 4'h1;
  localparam logic [OP_W-1:0] OP_ISZ  = 4'h2;
  localparam logic [OP_W-1:0] OP_BSA  = 4'h3;
  localparam logic [OP_W-1:0] OP_HALT = 4'hF;

  typedef enum logic [2:0] {
    CY_FETCH = 3'd0,
    CY_INDIR = 3'd1,
    CY_EXEC  = 3'd2,
    CY_INTR  = 3'd3,
    CY_HALT  = 3'd4
  } cycle_e;

  // one bit per register transfer the decoder can enable
  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mar_from_save;
    logic mbr_from_mem;
    logic mbr_from_pc;
    logic mbr_inc;
    logic ir_from_mbr;
    logic iraddr_from_mbr;
    logic pc_inc;
    logic pc_from_ir;
    logic pc_from_isr;
    logic acc_add;
    logic mem_write;
    logic last_step;
  } ctrl_t;

  function automatic logic is_memref(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_ISZ) || (op == OP_BSA);
  endfunction

endpackage

// File: rtl/hsc_sequencer.sv
module hsc_sequencer
  import hsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last_step_i,
  input  logic [OP_W-1:0]   fetched_op_i,
  input  logic              fetched_ind_i,
  input  logic              irq_req_i,
  output cycle_e            cycle_q,
  output logic [STEP_W-1:0] step_q,
  output logic              int_en_q,
  output logic              take_irq_o
);

  cycle_e next_cycle;

  // interrupt decision happens only in the closing step of execute
  assign take_irq_o = (cycle_q == CY_EXEC) && last_step_i && irq_req_i && int_en_q;

  always_comb begin
    next_cycle = cycle_q;
    case (cycle_q)
      CY_FETCH: begin
        // IR is being loaded this step, so the decision looks at MBR
        if (fetched_op_i == OP_HALT)                          next_cycle = CY_HALT;
        else if (fetched_ind_i && is_memref(fetched_op_i))    next_cycle = CY_INDIR;
        else                                                  next_cycle = CY_EXEC;
      end
      CY_INDIR: next_cycle = CY_EXEC;
      CY_EXEC:  next_cycle = take_irq_o ? CY_INTR : CY_FETCH;
      CY_INTR:  next_cycle = CY_FETCH;
      default:  next_cycle = CY_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cycle_q <= CY_FETCH;
      step_q  <= '0;
    end else if (cycle_q != CY_HALT) begin
      if (last_step_i) begin
        cycle_q <= next_cycle;
        step_q  <= '0;
      end else begin
        step_q  <= step_q + STEP_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          int_en_q <= 1'b1;
    else if (take_irq_o) int_en_q <= 1'b0;
  end

  assert_new_cycle_at_t1_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_q != $past(cycle_q)) |-> (step_q == '0));

  assert_fetch_three_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_q == CY_FETCH) |-> (step_q <= STEP_W'(2)));

  assert_intr_runs_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_q == CY_INTR) |-> !int_en_q);

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_q == CY_HALT) |=> (cycle_q == CY_HALT) && $stable(step_q));

endmodule

// File: rtl/hsc_decode.sv
module hsc_decode
  import hsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cycle_e            cycle_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [OP_W-1:0]   ir_op_i,
  input  logic              mbr_zero_i,
  output ctrl_t             ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    case (cycle_i)
      CY_FETCH: begin
        case (step_i)
          2'd0:    ctrl_o.mar_from_pc = 1'b1;
          2'd1: begin
            ctrl_o.mbr_from_mem = 1'b1;
            ctrl_o.pc_inc       = 1'b1;
          end
          default: begin
            ctrl_o.ir_from_mbr = 1'b1;
            ctrl_o.last_step   = 1'b1;
          end
        endcase
      end
      CY_INDIR: begin
        case (step_i)
          2'd0:    ctrl_o.mar_from_ir  = 1'b1;
          2'd1:    ctrl_o.mbr_from_mem = 1'b1;
          default: begin
            ctrl_o.iraddr_from_mbr = 1'b1;
            ctrl_o.last_step       = 1'b1;
          end
        endcase
      end
      CY_EXEC: begin
        case (ir_op_i)
          OP_ADD: begin
            case (step_i)
              2'd0:    ctrl_o.mar_from_ir  = 1'b1;
              2'd1:    ctrl_o.mbr_from_mem = 1'b1;
              default: begin
                ctrl_o.acc_add   = 1'b1;
                ctrl_o.last_step = 1'b1;
              end
            endcase
          end
          OP_ISZ: begin
            case (step_i)
              2'd0:    ctrl_o.mar_from_ir  = 1'b1;
              2'd1:    ctrl_o.mbr_from_mem = 1'b1;
              2'd2:    ctrl_o.mbr_inc      = 1'b1;
              default: begin
                ctrl_o.mem_write = 1'b1;
                ctrl_o.pc_inc    = mbr_zero_i;
                ctrl_o.last_step = 1'b1;
              end
            endcase
          end
          OP_BSA: begin
            case (step_i)
              2'd0: begin
                ctrl_o.mar_from_ir = 1'b1;
                ctrl_o.mbr_from_pc = 1'b1;
              end
              2'd1: begin
                ctrl_o.pc_from_ir = 1'b1;
                ctrl_o.mem_write  = 1'b1;
              end
              default: begin
                ctrl_o.pc_inc    = 1'b1;
                ctrl_o.last_step = 1'b1;
              end
            endcase
          end
          default: ctrl_o.last_step = 1'b1;
        endcase
      end
      CY_INTR: begin
        case (step_i)
          2'd0:    ctrl_o.mbr_from_pc = 1'b1;
          2'd1: begin
            ctrl_o.mar_from_save = 1'b1;
            ctrl_o.pc_from_isr   = 1'b1;
          end
          default: begin
            ctrl_o.mem_write = 1'b1;
            ctrl_o.last_step = 1'b1;
          end
        endcase
      end
      default: ctrl_o = '0;
    endcase
  end

  assert_mbr_one_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_o.mbr_from_mem, ctrl_o.mbr_from_pc, ctrl_o.mbr_inc}));

  assert_mbr_held_while_written_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o.mem_write |-> !(ctrl_o.mbr_from_mem || ctrl_o.mbr_inc || ctrl_o.mbr_from_pc));

  assert_pc_one_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_o.pc_inc, ctrl_o.pc_from_ir, ctrl_o.pc_from_isr}));

endmodule

// File: rtl/hsc_datapath.sv
module hsc_datapath
  import hsc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SAVE_ADDR = 0,
  parameter int ISR_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-6:0] pc_q,
  output logic [DATA_W-6:0] mar_q,
  output logic [DATA_W-1:0] mbr_q,
  output logic [DATA_W-1:0] ir_q,
  output logic [DATA_W-1:0] acc_q,
  output logic              mbr_zero_o
);

  localparam int ADDR_W = DATA_W - 5;
  localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
  localparam logic [ADDR_W-1:0] ISR_A  = ADDR_W'(ISR_ADDR);

  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] word_inc(input logic [DATA_W-1:0] w);
    return w + DATA_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] word_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_field(input logic [DATA_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] widen(input logic [ADDR_W-1:0] a);
    return DATA_W'(a);
  endfunction

  assign mbr_zero_o = (mbr_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                     mar_q <= '0;
    else if (ctrl_i.mar_from_pc)    mar_q <= pc_q;
    else if (ctrl_i.mar_from_ir)    mar_q <= addr_field(ir_q);
    else if (ctrl_i.mar_from_save)  mar_q <= SAVE_A;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     mbr_q <= '0;
    else if (ctrl_i.mbr_from_mem)   mbr_q <= mem_rdata_i;
    else if (ctrl_i.mbr_from_pc)    mbr_q <= widen(pc_q);
    else if (ctrl_i.mbr_inc)        mbr_q <= word_inc(mbr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       ir_q <= '0;
    else if (ctrl_i.ir_from_mbr)      ir_q <= mbr_q;
    else if (ctrl_i.iraddr_from_mbr)  ir_q[ADDR_W-1:0] <= addr_field(mbr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     pc_q <= '0;
    else if (ctrl_i.pc_from_isr)    pc_q <= ISR_A;
    else if (ctrl_i.pc_from_ir)     pc_q <= addr_field(ir_q);
    else if (ctrl_i.pc_inc)         pc_q <= addr_inc(pc_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     acc_q <= '0;
    else if (ctrl_i.acc_add)        acc_q <= word_add(acc_q, mbr_q);
  end

  assert_pc_steps_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_i.pc_inc |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

  assert_acc_moves_only_on_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_q) |-> $past(ctrl_i.acc_add));

  assert_indirect_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_i.iraddr_from_mbr |-> ir_q[DATA_W-5]);

  assert_isr_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_i.mar_from_save |=> (pc_q == ISR_A) && (mar_q == SAVE_A));

endmodule

// File: rtl/hw_seq_cpu.sv
module hw_seq_cpu
  import hsc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SAVE_ADDR = 0,
  parameter int ISR_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-6:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-6:0] pc_o,
  output logic [2:0]        cycle_o,
  output logic [1:0]        step_o
);

  localparam int ADDR_W = DATA_W - 5;

  ctrl_t              ctrl;
  cycle_e             cycle_q;
  logic [STEP_W-1:0]  step_q;
  logic               int_en_q;
  logic               ev_irq_taken;
  logic [ADDR_W-1:0]  pc_q;
  logic [ADDR_W-1:0]  mar_q;
  logic [DATA_W-1:0]  mbr_q;
  logic [DATA_W-1:0]  ir_q;
  logic [DATA_W-1:0]  acc_q;
  logic               mbr_zero;

  hsc_sequencer u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .last_step_i   (ctrl.last_step),
    .fetched_op_i  (mbr_q[DATA_W-1 -: OP_W]),
    .fetched_ind_i (mbr_q[DATA_W-5]),
    .irq_req_i     (irq_req),
    .cycle_q       (cycle_q),
    .step_q        (step_q),
    .int_en_q      (int_en_q),
    .take_irq_o    (ev_irq_taken)
  );

  hsc_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycle_i    (cycle_q),
    .step_i     (step_q),
    .ir_op_i    (ir_q[DATA_W-1 -: OP_W]),
    .mbr_zero_i (mbr_zero),
    .ctrl_o     (ctrl)
  );

  hsc_datapath #(
    .DATA_W    (DATA_W),
    .SAVE_ADDR (SAVE_ADDR),
    .ISR_ADDR  (ISR_ADDR)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_i      (ctrl),
    .mem_rdata_i (mem_rdata),
    .pc_q        (pc_q),
    .mar_q       (mar_q),
    .mbr_q       (mbr_q),
    .ir_q        (ir_q),
    .acc_q       (acc_q),
    .mbr_zero_o  (mbr_zero)
  );

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign mem_we    = ctrl.mem_write;
  assign acc_o     = acc_q;
  assign pc_o      = pc_q;
  assign cycle_o   = cycle_q;
  assign step_o    = step_q;

  assert_no_back_to_back_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq_taken |=> (cycle_q == CY_INTR) && !int_en_q);

  assert_no_write_in_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_q == CY_FETCH) |-> !mem_we);

endmodule

// File: tb/sim_hw_seq_cpu.sv
module sim_hw_seq_cpu;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int AW   = 11;
  localparam int MEMN = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq_req = 1'b0;
  logic [DW-1:0] mem_rdata, mem_wdata, acc_o;
  logic [AW-1:0] mem_addr, pc_o;
  logic          mem_we;
  logic [2:0]    cycle_o;
  logic [1:0]    step_o;

  logic [DW-1:0] mem     [MEMN];
  logic [DW-1:0] img     [MEMN];
  logic [DW-1:0] ref_mem [MEMN];
  logic          load_en = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  logic [AW-1:0] m_pc;
  logic [DW-1:0] m_acc;
  logic          m_ie;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_seq_cpu u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .acc_o     (acc_o),
    .pc_o      (pc_o),
    .cycle_o   (cycle_o),
    .step_o    (step_o)
  );

  // word memory: read shows the word at the current address, writes commit on the edge
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (load_en) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= img[i];
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < MEMN; i++) img[i] = '0;
  endtask

  task automatic start_run();
    for (int i = 0; i < MEMN; i++) ref_mem[i] = img[i];
    irq_req = 1'b0;
    rst_n   = 1'b0;
    load_en = 1'b1;
    repeat (4) @(negedge clk);
    load_en = 1'b0;
    chk(pc_o == '0,  "R1 reset pc", 32'(pc_o), 0);
    chk(acc_o == '0, "R1 reset accumulator", 32'(acc_o), 0);
    chk(cycle_o == 3'd0 && step_o == 2'd0, "R1 R11 reset cycle/step", {cycle_o, step_o}, 0);
    chk(mem_we == 1'b0, "R1 reset write enable", 32'(mem_we), 0);
    rst_n = 1'b1;
    m_pc  = '0;
    m_acc = '0;
    m_ie  = 1'b1;
  endtask

  // instruction-level model: returns the clock count of this instruction
  task automatic model_step(input bit irq_eff, output int cyc, output bit halt, output string tag);
    logic [DW-1:0] w, v;
    logic [3:0]    op;
    logic [AW-1:0] ea;
    w    = ref_mem[m_pc];
    m_pc = m_pc + 1'b1;
    op   = w[15:12];
    ea   = w[10:0];
    cyc  = 3;
    halt = 1'b0;
    tag  = "";
    if (op == 4'hF) begin
      halt = 1'b1;
      tag  = "R9";
      return;
    end
    if (w[11] && (op == 4'h1 || op == 4'h2 || op == 4'h3)) begin
      ea  = ref_mem[ea][10:0];
      cyc += 3;
      tag = {tag, "R7 "};
    end
    case (op)
      4'h1: begin
        m_acc = m_acc + ref_mem[ea];
        cyc += 3;
        tag = {tag, "R4"};
      end
      4'h2: begin
        v = ref_mem[ea] + 1'b1;
        ref_mem[ea] = v;
        if (v == '0) m_pc = m_pc + 1'b1;
        cyc += 4;
        tag = {tag, "R5"};
      end
      4'h3: begin
        ref_mem[ea] = DW'(m_pc);
        m_pc = ea + 1'b1;
        cyc += 3;
        tag = {tag, "R6"};
      end
      default: begin
        cyc += 1;
        tag = {tag, "R3"};
      end
    endcase
    if (irq_eff && m_ie) begin
      ref_mem[0] = DW'(m_pc);
      m_pc = 11'd1;
      m_ie = 1'b0;
      cyc += 3;
      tag = {tag, " R8"};
    end
  endtask

  // irq_mode: 0 never, 1 random with some pulses dropped during fetch, 2 always
  task automatic run_prog(input int max_insn, input int irq_mode);
    int    cyc;
    bit    halt;
    string tag;
    bit    irq_v, pulse, ok;
    logic [AW-1:0] pc_snap;
    int    bad;
    for (int n = 0; n < max_insn; n++) begin
      chk(pc_o == m_pc,   "R2 pc at instruction boundary", 32'(pc_o), 32'(m_pc));
      chk(acc_o == m_acc, "R4 accumulator at boundary", 32'(acc_o), 32'(m_acc));
      irq_v = (irq_mode == 2) ? 1'b1 : ((irq_mode == 1) ? ($urandom_range(0, 4) == 0) : 1'b0);
      pulse = (irq_mode == 1) && irq_v && ($urandom_range(0, 2) == 0);
      irq_req = irq_v;
      model_step(irq_v && !pulse, cyc, halt, tag);
      if (pulse) begin
        @(negedge clk);
        irq_req = 1'b0;
        repeat (cyc - 1) @(negedge clk);
      end else begin
        repeat (cyc) @(negedge clk);
      end
      if (halt) begin
        chk(cycle_o == 3'd4, "R9 R11 halted code right after fetch", 32'(cycle_o), 4);
        pc_snap = pc_o;
        chk(pc_o == m_pc, "R9 pc after halt fetch", 32'(pc_o), 32'(m_pc));
        irq_req = 1'b1;
        repeat (6) @(negedge clk);
        irq_req = 1'b0;
        chk(cycle_o == 3'd4 && pc_o == pc_snap && acc_o == m_acc, "R9 halt holds state",
            {cycle_o, pc_o}, {3'd4, pc_snap});
        break;
      end
      chk(cycle_o == 3'd0 && step_o == 2'd0, {tag, " R11 step count to next fetch t1"},
          {cycle_o, step_o}, 0);
    end
    irq_req = 1'b0;
    bad = -1;
    for (int i = 0; i < MEMN; i++) begin
      if (bad < 0 && mem[i] !== ref_mem[i]) bad = i;
    end
    ok = (bad < 0);
    if (ok) chk(1'b1, "R10 memory image", 0, 0);
    else    chk(1'b0, $sformatf("R10 memory image word %0d", bad), 32'(mem[bad]), 32'(ref_mem[bad]));
  endtask

  task automatic gen_random();
    logic [3:0] op;
    clear_img();
    for (int i = 0; i < 64; i++) begin
      case ($urandom_range(0, 9))
        0, 1, 2: op = 4'h1;
        3, 4:    op = 4'h2;
        5:       op = 4'h3;
        6:       op = 4'h7;
        7:       op = 4'h0;
        8:       op = (i > 48) ? 4'hF : 4'h1;
        default: op = 4'h2;
      endcase
      img[i] = {op, 1'($urandom_range(0, 3) == 0), 11'($urandom_range(2, 63))};
      if ($urandom_range(0, 9) == 0) img[i] = 16'hFFFF;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5EED));

    // directed: add, indirect add, skip on wrap to zero, no skip, save-and-branch,
    // undefined opcodes with the indirect flag, halt
    clear_img();
    img[0]     = 16'h1020;
    img[1]     = 16'h1821;
    img[2]     = 16'h2023;
    img[3]     = 16'hF000;
    img[4]     = 16'h2024;
    img[5]     = 16'h3030;
    img[16'h31] = 16'h7800;
    img[16'h32] = 16'h0800;
    img[16'h33] = 16'hF800;
    img[16'h20] = 16'd3;
    img[16'h21] = 16'h0022;
    img[16'h22] = 16'd5;
    img[16'h23] = 16'hFFFF;
    img[16'h24] = 16'd5;
    start_run();
    run_prog(20, 0);
    chk(acc_o == 16'd8, "R4 R7 directed sum", 32'(acc_o), 8);
    chk(mem[16'h30] == 16'd6, "R6 saved return address", 32'(mem[16'h30]), 6);
    chk(mem[16'h23] == 16'd0, "R5 wrapped operand written back", 32'(mem[16'h23]), 0);

    // directed: request held high, taken once, enable stays cleared
    clear_img();
    img[0] = 16'h1020;
    img[1] = 16'h1020;
    img[2] = 16'hF000;
    img[16'h20] = 16'd7;
    start_run();
    run_prog(10, 2);
    chk(mem[0] == 16'd1, "R8 saved pc at word 0", 32'(mem[0]), 1);
    chk(acc_o == 16'd14, "R8 resumed after interrupt", 32'(acc_o), 14);

    // random programs with random and dropped requests
    for (int r = 0; r < 8; r++) begin
      gen_random();
      start_run();
      run_prog(40, (r % 3 == 0) ? 0 : 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule